// File: doc/BRIEF.md
# Indirect Memory Access Register Window

This block gives a host with only byte-wide I/O cycles a path into a 32-bit address space. The host sees a small window of byte ports, selected by an 8-bit port offset. It can read a fixed four-byte identification constant. It loads a 32-bit pointer one byte at a time and builds a 32-bit data word the same way. Writing the most significant byte of the data word sends the whole word downstream as a single 32-bit write. Reading one of the low data ports fetches one byte from the pointer plus the port's byte offset.

Every downstream access is sent to one of two targets, chosen by its address. Addresses below 16 MiB go to a register space unchanged. Addresses at or above 16 MiB go to a linear memory space, rebased so that 16 MiB becomes zero. The downstream side uses a plain request/acknowledge handshake. While a request is outstanding the window reports busy and accepts no host access. Two of the data port groups also advance the pointer by four after every write, so software can stream words into consecutive addresses. A separate 4-bit mode field is loaded from an extended control write.

Top module: `ind_access_window`

## Requirements
- R1: A read of offset 0x00, 0x01, 0x02 or 0x03 returns 0x65, 0xD0, 0x16 or 0x2B in that order, with hostRdValid high in the cycle after the read is accepted. Writes to these offsets change nothing that can be observed.
- R2: A write to offset 0x04+k (k = 0 for the least significant byte, up to 3) replaces byte k of the pointer and leaves its other three bytes unchanged.
- R3: Offsets 0x08-0x0B, 0x0C-0x0F, 0x10-0x13 and 0x14-0x17 alias the data word. In each of them, offset bits [1:0] select which data byte a write replaces.
- R4: A write to 0x0B, 0x0F, 0x13 or 0x17 launches exactly one request with reqWrite=1. The request carries the full data word, including the byte just written, at the pointer value held before that write. No other write offset launches a request.
- R5: A downstream address A below 0x1000000 is presented with reqLinear=0 and reqAddr=A. Otherwise it is presented with reqLinear=1 and reqAddr=A-0x1000000.
- R6: Every accepted write to offsets 0x10-0x17 adds 4 to the pointer after the write. A commit from 0x13 or 0x17 uses the pointer value from before the increment.
- R7: A read of offset 0x08+k launches a request with reqWrite=0 at pointer+k. The byte on ackRdData in the acknowledge cycle appears on hostRdData, with hostRdValid high, in the following cycle.
- R8: The 8-bit port offset is fully decoded. A read of any offset other than 0x00-0x03 and 0x08-0x0B returns 0x00 in the next cycle and launches no request.
- R9: A synchronous active-low reset clears the pointer, the data word and the mode field to zero, and leaves reqValid, busy and hostRdValid low.
- R10: A ctrlWrEn pulse loads ctrlWrNibble into modeOut, visible in the next cycle.
- R11: Once raised, reqValid stays high with reqWrite, reqLinear, reqAddr and reqWrData stable until a cycle with reqAck. It drops in the cycle after that one. busy is high exactly while reqValid is high. Host reads and writes presented while busy is high are dropped without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| hostOfs | input | 8 | Port offset of the host access |
| hostWrEn | input | 1 | Host byte write strobe |
| hostRdEn | input | 1 | Host byte read strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte |
| hostRdValid | output | 1 | hostRdData holds a completed read |
| busy | output | 1 | Downstream request outstanding; host accesses are not taken |
| ctrlWrEn | input | 1 | Extended control write strobe |
| ctrlWrNibble | input | 4 | Low nibble of the extended control byte |
| modeOut | output | 4 | Stored mode field |
| reqValid | output | 1 | Downstream request pending |
| reqWrite | output | 1 | 1 for a 32-bit write, 0 for a byte read |
| reqLinear | output | 1 | 1 selects linear memory, 0 the register space |
| reqAddr | output | 32 | Address within the selected target |
| reqWrData | output | 32 | Write data word |
| reqAck | input | 1 | Downstream acknowledge |
| ackRdData | input | 8 | Read byte returned with reqAck |

## Verification
A single host write to 0x13 or 0x17 does three things on the same clock edge: it replaces a data byte, it commits the word downstream, and it advances the pointer. The bench writes into the post-increment group with a known pointer. It then checks that each request carries the freshly merged word at the pre-increment address, and that the next commit lands four bytes higher. A second collision is a host access that arrives while a request is still pending. The bench withholds the acknowledge, pulses a pointer write and a signature read during that wait, and then shows that neither had any effect: no read response comes back, and the next read request still goes to the old pointer.

// File: rtl/iaw_pkg.sv
package iaw_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int SEL_W      = $clog2(WORD_BYTES);
  localparam int OFS_W      = 8;

  // Port offset map; the byte-lane decode depends on these starting on
  // multiples of WORD_BYTES.
  localparam logic [OFS_W-1:0] OFS_SIG_FIRST  = 8'h00;
  localparam logic [OFS_W-1:0] OFS_PTR_FIRST  = 8'h04;
  localparam logic [OFS_W-1:0] OFS_DATA_FIRST = 8'h08;
  localparam logic [OFS_W-1:0] OFS_DATA_LAST  = 8'h17;
  localparam logic [OFS_W-1:0] OFS_INC_FIRST  = 8'h10;

  // Strobes from control to datapath, all single-cycle.
  typedef struct packed {
    logic             addrWe;
    logic             dataWe;
    logic [SEL_W-1:0] byteSel;
    logic             addrInc;
    logic             launchWr;
    logic             launchRd;
    logic             sigRd;
    logic             zeroRd;
    logic             ackRd;
  } iaw_stb_t;
endpackage

// File: rtl/iaw_ctrl.sv
module iaw_ctrl
  import iaw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [OFS_W-1:0] hostOfs,
  input  logic             hostWrEn,
  input  logic             hostRdEn,
  input  logic             reqAck,
  output iaw_stb_t         stb,
  output logic             reqValid,
  output logic             reqWrite,
  output logic             hostRdValid,
  output logic             busy
);
  localparam logic [OFS_W-1:0] LANES = OFS_W'(WORD_BYTES);

  logic reqValidQ, reqWriteQ, rdValidQ;
  logic wrAcc, rdAcc;
  logic inSig, inPtr, inData, inRdPort, inInc, topLane;

  // Offset decode.
  always_comb begin
    inSig    = (hostOfs >= OFS_SIG_FIRST)  && (hostOfs < OFS_SIG_FIRST + LANES);
    inPtr    = (hostOfs >= OFS_PTR_FIRST)  && (hostOfs < OFS_PTR_FIRST + LANES);
    inData   = (hostOfs >= OFS_DATA_FIRST) && (hostOfs <= OFS_DATA_LAST);
    inRdPort = (hostOfs >= OFS_DATA_FIRST) && (hostOfs < OFS_DATA_FIRST + LANES);
    inInc    = (hostOfs >= OFS_INC_FIRST)  && (hostOfs <= OFS_DATA_LAST);
    topLane  = (hostOfs[SEL_W-1:0] == {SEL_W{1'b1}});
  end

  // A host access is taken only when no request is outstanding; write wins.
  assign wrAcc = hostWrEn && !reqValidQ;
  assign rdAcc = hostRdEn && !hostWrEn && !reqValidQ;

  always_comb begin
    stb          = '0;
    stb.byteSel  = hostOfs[SEL_W-1:0];
    stb.addrWe   = wrAcc && inPtr;
    stb.dataWe   = wrAcc && inData;
    stb.addrInc  = wrAcc && inInc;
    stb.launchWr = wrAcc && inData && topLane;
    stb.launchRd = rdAcc && inRdPort;
    stb.sigRd    = rdAcc && inSig;
    stb.zeroRd   = rdAcc && !inSig && !inRdPort;
    stb.ackRd    = reqValidQ && reqAck && !reqWriteQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValidQ <= 1'b0;
      reqWriteQ <= 1'b0;
      rdValidQ  <= 1'b0;
    end else begin
      rdValidQ <= stb.sigRd || stb.zeroRd || stb.ackRd;
      if (reqValidQ && reqAck) begin
        reqValidQ <= 1'b0;
      end else if (stb.launchWr || stb.launchRd) begin
        reqValidQ <= 1'b1;
        reqWriteQ <= stb.launchWr;
      end
    end
  end

  assign reqValid    = reqValidQ;
  assign reqWrite    = reqWriteQ;
  assign hostRdValid = rdValidQ;
  assign busy        = reqValidQ;
endmodule

// File: rtl/iaw_datapath.sv
module iaw_datapath
  import iaw_pkg::*;
#(
  parameter int                REG_SPACE_BITS = 24,
  parameter int                PTR_STEP       = 4,
  parameter int                MODE_W         = 4,
  parameter logic [WORD_W-1:0] SIGNATURE      = 32'h2B16_D065
) (
  input  logic              clk,
  input  logic              rstN,
  input  iaw_stb_t          stb,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic [BYTE_W-1:0] ackRdData,
  input  logic              ctrlWrEn,
  input  logic [MODE_W-1:0] ctrlWrNibble,
  output logic [BYTE_W-1:0] hostRdData,
  output logic [MODE_W-1:0] modeOut,
  output logic              reqLinear,
  output logic [WORD_W-1:0] reqAddr,
  output logic [WORD_W-1:0] reqWrData
);
  localparam logic [WORD_W-1:0] LIN_BASE = {{(WORD_W-1){1'b0}}, 1'b1} << REG_SPACE_BITS;
  localparam logic [WORD_W-1:0] STEP     = WORD_W'(PTR_STEP);

  logic [WORD_W-1:0] ptrQ, dataQ, ptrMerged, dataMerged, ptrNext;
  logic [WORD_W-1:0] srcAddr, reqAddrQ, reqDataQ;
  logic [BYTE_W-1:0] rdByteQ, sigByte;
  logic [MODE_W-1:0] modeQ;
  logic              reqLinQ, srcLinear;

  // Byte lane replacement for pointer and data word.
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic hit;
    assign hit = (stb.byteSel == SEL_W'(g));
    assign ptrMerged[g*BYTE_W +: BYTE_W]  = (stb.addrWe && hit) ? hostWrData
                                          : ptrQ[g*BYTE_W +: BYTE_W];
    assign dataMerged[g*BYTE_W +: BYTE_W] = (stb.dataWe && hit) ? hostWrData
                                          : dataQ[g*BYTE_W +: BYTE_W];
  end

  assign ptrNext   = stb.addrInc ? ptrQ + STEP : ptrMerged;
  assign srcAddr   = stb.launchWr ? ptrQ : ptrQ + WORD_W'(stb.byteSel);
  assign srcLinear = (srcAddr >= LIN_BASE);
  assign sigByte   = SIGNATURE[{stb.byteSel, 3'b000} +: BYTE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ     <= '0;
      dataQ    <= '0;
      reqAddrQ <= '0;
      reqDataQ <= '0;
      reqLinQ  <= 1'b0;
      rdByteQ  <= '0;
      modeQ    <= '0;
    end else begin
      ptrQ  <= ptrNext;
      dataQ <= dataMerged;
      if (stb.launchWr || stb.launchRd) begin
        reqLinQ  <= srcLinear;
        reqAddrQ <= srcLinear ? srcAddr - LIN_BASE : srcAddr;
      end
      if (stb.launchWr) reqDataQ <= dataMerged;
      if (stb.sigRd)       rdByteQ <= sigByte;
      else if (stb.zeroRd) rdByteQ <= '0;
      else if (stb.ackRd)  rdByteQ <= ackRdData;
      if (ctrlWrEn) modeQ <= ctrlWrNibble;
    end
  end

  assign hostRdData = rdByteQ;
  assign modeOut    = modeQ;
  assign reqLinear  = reqLinQ;
  assign reqAddr    = reqAddrQ;
  assign reqWrData  = reqDataQ;
endmodule

// File: rtl/ind_access_window.sv
module ind_access_window
  import iaw_pkg::*;
#(
  parameter int                REG_SPACE_BITS = 24,
  parameter int                PTR_STEP       = 4,
  parameter int                MODE_W         = 4,
  parameter logic [WORD_W-1:0] SIGNATURE      = 32'h2B16_D065
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFS_W-1:0]  hostOfs,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [BYTE_W-1:0] hostWrData,
  output logic [BYTE_W-1:0] hostRdData,
  output logic              hostRdValid,
  output logic              busy,
  input  logic              ctrlWrEn,
  input  logic [MODE_W-1:0] ctrlWrNibble,
  output logic [MODE_W-1:0] modeOut,
  output logic              reqValid,
  output logic              reqWrite,
  output logic              reqLinear,
  output logic [WORD_W-1:0] reqAddr,
  output logic [WORD_W-1:0] reqWrData,
  input  logic              reqAck,
  input  logic [BYTE_W-1:0] ackRdData
);
  iaw_stb_t stb;

  iaw_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .hostOfs    (hostOfs),
    .hostWrEn   (hostWrEn),
    .hostRdEn   (hostRdEn),
    .reqAck     (reqAck),
    .stb        (stb),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .hostRdValid(hostRdValid),
    .busy       (busy)
  );

  iaw_datapath #(
    .REG_SPACE_BITS(REG_SPACE_BITS),
    .PTR_STEP      (PTR_STEP),
    .MODE_W        (MODE_W),
    .SIGNATURE     (SIGNATURE)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .hostWrData  (hostWrData),
    .ackRdData   (ackRdData),
    .ctrlWrEn    (ctrlWrEn),
    .ctrlWrNibble(ctrlWrNibble),
    .hostRdData  (hostRdData),
    .modeOut     (modeOut),
    .reqLinear   (reqLinear),
    .reqAddr     (reqAddr),
    .reqWrData   (reqWrData)
  );
endmodule

// File: rtl/ind_access_window_chk.sv
module ind_access_window_chk
  import iaw_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [OFS_W-1:0]  hostOfs,
  input logic              hostWrEn,
  input logic              hostRdEn,
  input logic [BYTE_W-1:0] hostRdData,
  input logic              hostRdValid,
  input logic              busy,
  input logic              ctrlWrEn,
  input logic [MODE_W-1:0] ctrlWrNibble,
  input logic [MODE_W-1:0] modeOut,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqLinear,
  input logic [WORD_W-1:0] reqAddr,
  input logic [WORD_W-1:0] reqWrData,
  input logic              reqAck
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck |=> reqValid && $stable(reqAddr) && $stable(reqWrData)
                            && $stable(reqWrite) && $stable(reqLinear));
  // R11
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqAck |=> !reqValid && !busy);
  // R1
  sig_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRdEn && !hostWrEn && !busy && hostOfs == 8'h00 |=> hostRdValid && hostRdData == 8'h65);
  // R4
  commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn && !busy && (hostOfs == 8'h0B || hostOfs == 8'h0F || hostOfs == 8'h13 || hostOfs == 8'h17)
    |=> reqValid && reqWrite);
  // R7
  rd_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRdEn && !hostWrEn && !busy && hostOfs[7:2] == 6'd2 |=> reqValid && !reqWrite);
  // R7
  rd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hostRdValid, reqValid && !reqWrite}));
  // R5
  reg_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqLinear |-> reqAddr < 32'h0100_0000);
  // R10
  mode_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> modeOut == $past(ctrlWrNibble));
endmodule

bind ind_access_window ind_access_window_chk #(.MODE_W(MODE_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .hostOfs     (hostOfs),
  .hostWrEn    (hostWrEn),
  .hostRdEn    (hostRdEn),
  .hostRdData  (hostRdData),
  .hostRdValid (hostRdValid),
  .busy        (busy),
  .ctrlWrEn    (ctrlWrEn),
  .ctrlWrNibble(ctrlWrNibble),
  .modeOut     (modeOut),
  .reqValid    (reqValid),
  .reqWrite    (reqWrite),
  .reqLinear   (reqLinear),
  .reqAddr     (reqAddr),
  .reqWrData   (reqWrData),
  .reqAck      (reqAck)
);

// File: tb/ind_access_window_tb_top.sv
module ind_access_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  hostOfs = '0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [7:0]  hostWrData = '0;
  logic [7:0]  hostRdData;
  logic        hostRdValid, busy;
  logic        ctrlWrEn = 1'b0;
  logic [3:0]  ctrlWrNibble = '0;
  logic [3:0]  modeOut;
  logic        reqValid, reqWrite, reqLinear;
  logic [31:0] reqAddr, reqWrData;
  logic        reqAck = 1'b0;
  logic [7:0]  ackRdData = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_access_window dut_i (
    .clk(clk), .rstN(rstN), .hostOfs(hostOfs), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .hostRdValid(hostRdValid), .busy(busy),
    .ctrlWrEn(ctrlWrEn), .ctrlWrNibble(ctrlWrNibble), .modeOut(modeOut),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqLinear(reqLinear), .reqAddr(reqAddr),
    .reqWrData(reqWrData), .reqAck(reqAck), .ackRdData(ackRdData)
  );

  // wr, ofs, wdata/ack byte, expReq, expLin, expAddr, expData, expRd, req tag
  typedef struct packed {
    logic        wr;
    logic [7:0]  ofs;
    logic [7:0]  wd;
    logic        expReq;
    logic        expLin;
    logic [31:0] expAddr;
    logic [31:0] expData;
    logic [7:0]  expRd;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    // R1 signature bytes, write ignored
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 8'h65, 8'd1},
    {1'b0, 8'h01, 8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 8'hD0, 8'd1},
    {1'b0, 8'h02, 8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 8'h16, 8'd1},
    {1'b0, 8'h03, 8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 8'h2B, 8'd1},
    {1'b1, 8'h00, 8'hFF, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd1},
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 8'h65, 8'd1},
    // R8 unlisted offsets read zero, no request
    {1'b0, 8'h05, 8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd8},
    {1'b0, 8'h20, 8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd8},
    {1'b0, 8'h0C, 8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd8},
    {1'b0, 8'h17, 8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd8},
    // R2 pointer bytes -> 0x00302010
    {1'b1, 8'h04, 8'h10, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd2},
    {1'b1, 8'h05, 8'h20, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd2},
    {1'b1, 8'h06, 8'h30, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd2},
    {1'b1, 8'h07, 8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd2},
    // R3 data bytes, R4 commit at 0x0B
    {1'b1, 8'h08, 8'h11, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd3},
    {1'b1, 8'h09, 8'h22, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd3},
    {1'b1, 8'h0A, 8'h33, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd3},
    {1'b1, 8'h0B, 8'h44, 1'b1, 1'b0, 32'h0030_2010, 32'h4433_2211, 8'h00, 8'd4},
    // R2 single byte replace -> 0x00002010; R3 alias group 0x0C commits
    {1'b1, 8'h06, 8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd2},
    {1'b1, 8'h0F, 8'h99, 1'b1, 1'b0, 32'h0000_2010, 32'h9933_2211, 8'h00, 8'd3},
    // R5 linear target: pointer 0x01002010 -> rebased 0x2010
    {1'b1, 8'h07, 8'h01, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd2},
    {1'b1, 8'h0E, 8'h77, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd3},
    {1'b1, 8'h0B, 8'hAA, 1'b1, 1'b1, 32'h0000_2010, 32'hAA77_2211, 8'h00, 8'd5},
    // R6 post-increment groups, commit at pre-increment pointer
    {1'b1, 8'h10, 8'h01, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd6},
    {1'b1, 8'h13, 8'h02, 1'b1, 1'b1, 32'h0000_2014, 32'h0277_2201, 8'h00, 8'd6},
    {1'b1, 8'h17, 8'h03, 1'b1, 1'b1, 32'h0000_2018, 32'h0377_2201, 8'h00, 8'd6},
    // R7 reads at pointer 0x0100201C plus lane
    {1'b0, 8'h08, 8'h5A, 1'b1, 1'b1, 32'h0000_201C, 32'h0, 8'h5A, 8'd7},
    {1'b0, 8'h0B, 8'hC3, 1'b1, 1'b1, 32'h0000_201F, 32'h0, 8'hC3, 8'd7},
    // R5 boundary: pointer 0x00FFFFFE
    {1'b1, 8'h04, 8'hFE, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd2},
    {1'b1, 8'h05, 8'hFF, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd2},
    {1'b1, 8'h06, 8'hFF, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd2},
    {1'b1, 8'h07, 8'h00, 1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'd2},
    {1'b0, 8'h09, 8'h11, 1'b1, 1'b0, 32'h00FF_FFFF, 32'h0, 8'h11, 8'd5},
    {1'b0, 8'h0A, 8'h22, 1'b1, 1'b1, 32'h0000_0000, 32'h0, 8'h22, 8'd5}
  };

  task automatic chk(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [7:0] ofs, input logic [7:0] wd);
    @(negedge clk);
    while (busy) @(negedge clk);
    hostWrEn = wr; hostRdEn = !wr; hostOfs = ofs; hostWrData = wd;
    @(negedge clk);
    hostWrEn = 1'b0; hostRdEn = 1'b0;
  endtask

  // Called at the negedge after the launching edge.
  task automatic serve(input bit expWr, input bit expLin, input logic [31:0] expAddr,
                       input logic [31:0] expData, input logic [7:0] ackByte, input int req);
    int n = 0;
    while (!reqValid && n < 20) begin @(negedge clk); n++; end
    chk(reqValid === 1'b1 && busy === 1'b1, req, {30'd0, busy, reqValid}, 32'h3);
    chk(reqWrite === expWr, req, {31'd0, reqWrite}, {31'd0, expWr});
    chk(reqLinear === expLin, req, {31'd0, reqLinear}, {31'd0, expLin});
    chk(reqAddr === expAddr, req, reqAddr, expAddr);
    if (expWr) chk(reqWrData === expData, req, reqWrData, expData);
    reqAck = 1'b1; ackRdData = ackByte;
    @(negedge clk);
    reqAck = 1'b0;
    // R11 cleared after acknowledge
    chk(!reqValid && !busy, 11, {30'd0, busy, reqValid}, 32'h0);
    if (!expWr) chk(hostRdValid === 1'b1 && hostRdData === ackByte, 7, {23'd0, hostRdValid, hostRdData},
                    {24'd1, ackByte});
  endtask

  task automatic do_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired actual busy=%0b expected run end", busy);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    chk(!reqValid && !busy && !hostRdValid && modeOut == 4'h0, 9,
        {25'd0, reqValid, busy, hostRdValid, modeOut}, 32'h0);
    // R9 data and pointer cleared: lone top byte commits 0x80000000 at 0
    issue(1'b1, 8'h0B, 8'h80);
    chk(reqValid && reqAddr == 32'h0 && reqWrData == 32'h8000_0000 && !reqLinear, 9,
        reqWrData, 32'h8000_0000);
    // R11 stall: hold off ack, present a pointer write and a read
    hostWrEn = 1'b1; hostOfs = 8'h04; hostWrData = 8'h55;
    @(negedge clk);
    hostWrEn = 1'b0;
    chk(busy && reqValid && reqAddr == 32'h0 && reqWrData == 32'h8000_0000, 11, reqAddr, 32'h0);
    hostRdEn = 1'b1; hostOfs = 8'h00;
    @(negedge clk);
    hostRdEn = 1'b0;
    chk(!hostRdValid && busy, 11, {31'd0, hostRdValid}, 32'h0);
    serve(1'b1, 1'b0, 32'h0, 32'h8000_0000, 8'h00, 11);
    // R11 stalled pointer write had no effect: read goes to 0
    issue(1'b0, 8'h08, 8'h3C);
    serve(1'b0, 1'b0, 32'h0, 32'h0, 8'h3C, 11);

    // R10 mode nibble
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrNibble = 4'h7;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    chk(modeOut == 4'h7, 10, {28'd0, modeOut}, 32'h7);
    ctrlWrEn = 1'b1; ctrlWrNibble = 4'hC;
    @(negedge clk);
    ctrlWrEn = 1'b0; ctrlWrNibble = 4'h3;
    @(negedge clk);
    chk(modeOut == 4'hC, 10, {28'd0, modeOut}, 32'hC);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].wr, VECS[i].ofs, VECS[i].wd);
      if (VECS[i].expReq) begin
        serve(VECS[i].wr, VECS[i].expLin, VECS[i].expAddr, VECS[i].expData, VECS[i].wd,
              int'(VECS[i].tag));
      end else begin
        chk(!reqValid, int'(VECS[i].tag), {31'd0, reqValid}, 32'h0);
        if (!VECS[i].wr)
          chk(hostRdValid === 1'b1 && hostRdData === VECS[i].expRd, int'(VECS[i].tag),
              {23'd0, hostRdValid, hostRdData}, {24'd1, VECS[i].expRd});
      end
    end

    // R9 reset again after state was built up
    do_reset();
    chk(modeOut == 4'h0 && !busy, 9, {28'd0, modeOut}, 32'h0);
    issue(1'b1, 8'h0F, 8'h01);
    serve(1'b1, 1'b0, 32'h0, 32'h0100_0000, 8'h00, 9);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule